// File: doc/BRIEF.md
# Dual-Mode Message Interrupt Flag Register

This block keeps the 32 interrupt flags of a message controller that has 32 message buffers and an optional receive FIFO. Each buffer reports a finished transmission or reception with a one-cycle pulse. The matching flag latches that event until software clears it by writing a one to the flag. A per-bit mask selects which flags can drive the single interrupt request.

The upper 24 flags always belong to buffers 31 to 8. The meaning of the low byte depends on a FIFO-enable control. With the FIFO off, the low byte behaves exactly like the upper bits and serves buffers 7 to 0. With the FIFO on, the low byte reports FIFO state instead. Bit 7 reports a lost frame. Bit 6 reports an almost-full warning. Bit 5 reports that frames are waiting. Bits 4 to 0 are reserved. When a software write actually changes the mode, the whole low byte is cleared, because its earlier contents no longer mean anything.

Top module: `msg_irq_flags`

## Requirements
- R1: Flags 31 to 8 each set on the cycle after the completion pulse of the matching buffer, in either mode, and hold until cleared.
- R2: With the FIFO off, flags 7 to 0 set from completion pulses 7 to 0 in the same way. Unread-count changes have no effect on them.
- R3: A write-one-to-clear strobe clears every flag whose data bit is 1. When a set event and a clear reach the same flag in the same cycle, the flag stays set (except flag 5, see R7).
- R4: With the FIFO on, flag 7 sets after a dropped-frame pulse only when the mailbox-capture input is low in that cycle.
- R5: With the FIFO on, flag 6 sets only when the sampled unread count goes from 4 in one cycle to 5 in the next. A jump from below 4 straight to 5 does not set it.
- R6: If flag 6 is cleared while the unread count is above 4, it does not set again until the count has dropped to 4 and then risen to 5.
- R7: With the FIFO on, flag 5 sets whenever the unread count is non-zero. A clear of flag 5 takes effect for one cycle, and the flag sets again on the next cycle if frames remain.
- R8: With the FIFO on, flags 4 to 0 read as 0, and completion pulses 7 to 0 are ignored.
- R9: A write to the mode control that changes its value clears flags 7 to 0 on the next cycle and leaves flags 31 to 8 unchanged. A write of the current value changes nothing.
- R10: The interrupt request equals the OR of (flags AND mask), registered one cycle after the flags. The mask register loads on its own write strobe.
- R11: After reset, all flags are 0, the mask is 0, the interrupt request is low and the FIFO mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 32 | Per-buffer completion pulses |
| mode_wr_i | input | 1 | Write strobe for the FIFO-enable control |
| mode_wdata_i | input | 1 | New FIFO-enable value (1 = FIFO on) |
| fifo_cnt_i | input | 3 | Number of unread frames in the FIFO (0 to 6) |
| fifo_drop_i | input | 1 | An incoming frame found the FIFO full |
| fifo_mb_hit_i | input | 1 | The same frame was captured by a mailbox |
| clr_wr_i | input | 1 | Write-one-to-clear strobe for the flags |
| clr_wdata_i | input | 32 | Flags to clear (1 = clear) |
| mask_wr_i | input | 1 | Write strobe for the interrupt mask |
| mask_wdata_i | input | 32 | New mask value (1 = bit enabled) |
| fifo_mode_o | output | 1 | Current FIFO-enable state |
| flags_o | output | 32 | Interrupt flag vector |
| irq_o | output | 1 | Masked, ORed interrupt request |

## Verification
Every flag, the mode state and the mask change on the first rising edge after their stimulus. The interrupt request lags the flags by one more edge. The unread count is registered once for the warning detector, so the 4-to-5 step must span two edges, and the flag appears after the edge that samples 5. The bench drives all inputs at the falling edge and samples at the following falling edge, one rising edge later. For the interrupt request it checks both that edge and the next, so a result that comes a cycle early or late is caught.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
   // width of the field whose meaning depends on the FIFO mode
   localparam int unsigned REMAP_W   = 8;
   // positions decoded by the FIFO-mode logic
   localparam int unsigned OVF_BIT   = 7;
   localparam int unsigned WARN_BIT  = 6;
   localparam int unsigned AVAIL_BIT = 5;

   typedef struct packed {
      logic ovf;
      logic warn;
      logic avail;
   } fifo_evt_t;
endpackage

// File: rtl/msg_irq_fifo_mon.sv
module msg_irq_fifo_mon
   import msg_irq_pkg::*;
#(
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned WARN_LVL = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fifo_on_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             drop_i,
   input  logic             mb_hit_i,
   output fifo_evt_t        evt_o
);
   localparam logic [CNT_W-1:0] LVL_LO = CNT_W'(WARN_LVL);
   localparam logic [CNT_W-1:0] LVL_HI = CNT_W'(WARN_LVL + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_i;
   end

   always_comb begin
      evt_o.ovf   = fifo_on_i && drop_i && !mb_hit_i;
      evt_o.warn  = fifo_on_i && (cnt_q == LVL_LO) && (cnt_i == LVL_HI);
      evt_o.avail = fifo_on_i && (cnt_i != '0);
   end

   // R5
   warn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o.warn |-> (cnt_i > cnt_q));
endmodule

// File: rtl/msg_irq_flag_bank.sv
module msg_irq_flag_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic [W-1:0] zero_i,
   output logic [W-1:0] flags_o
);
   logic [W-1:0] flags_q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        flags_q[i] <= 1'b0;
         else if (zero_i[i]) flags_q[i] <= 1'b0;
         else if (set_i[i])  flags_q[i] <= 1'b1;
         else if (clr_i[i])  flags_q[i] <= 1'b0;
      end
   end

   assign flags_o = flags_q;

   // R3
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_i & ~zero_i)) |=>
         ((flags_q & $past(set_i & ~zero_i)) == $past(set_i & ~zero_i)));

   // R9
   zero_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|zero_i) |=> ((flags_q & $past(zero_i)) == '0));
endmodule

// File: rtl/msg_irq_req.sv
module msg_irq_req #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         mask_wr_i,
   input  logic [W-1:0] mask_wdata_i,
   input  logic [W-1:0] flags_i,
   output logic         irq_o
);
   logic [W-1:0] mask_q;
   logic         irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (mask_wr_i) mask_q <= mask_wdata_i;
         irq_q <= |(flags_i & mask_q);
      end
   end

   assign irq_o = irq_q;

   // R10
   irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> $past(|flags_i));
endmodule

// File: rtl/msg_irq_flags.sv
module msg_irq_flags
   import msg_irq_pkg::*;
#(
   parameter int unsigned NUM_MB   = 32,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned WARN_LVL = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_MB-1:0] done_i,
   input  logic              mode_wr_i,
   input  logic              mode_wdata_i,
   input  logic [CNT_W-1:0]  fifo_cnt_i,
   input  logic              fifo_drop_i,
   input  logic              fifo_mb_hit_i,
   input  logic              clr_wr_i,
   input  logic [NUM_MB-1:0] clr_wdata_i,
   input  logic              mask_wr_i,
   input  logic [NUM_MB-1:0] mask_wdata_i,
   output logic              fifo_mode_o,
   output logic [NUM_MB-1:0] flags_o,
   output logic              irq_o
);
   localparam logic [NUM_MB-1:0] LOW_MASK = NUM_MB'((64'd1 << REMAP_W) - 64'd1);

   if (NUM_MB < REMAP_W) begin : g_bad_mb
      $error("NUM_MB must cover the remapped byte");
   end
   if ((1 << CNT_W) <= (WARN_LVL + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for the warning level");
   end

   logic              mode_q;
   logic              mode_chg;
   fifo_evt_t         evt;
   logic [NUM_MB-1:0] set_vec;
   logic [NUM_MB-1:0] clr_vec;
   logic [NUM_MB-1:0] zero_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mode_q <= 1'b0;
      else if (mode_wr_i) mode_q <= mode_wdata_i;
   end

   assign mode_chg = mode_wr_i && (mode_wdata_i != mode_q);
   assign clr_vec  = clr_wr_i ? clr_wdata_i : '0;
   assign zero_vec = mode_chg ? LOW_MASK : '0;

   msg_irq_fifo_mon #(
      .CNT_W    (CNT_W),
      .WARN_LVL (WARN_LVL)
   ) u_fifo_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fifo_on_i (mode_q),
      .cnt_i     (fifo_cnt_i),
      .drop_i    (fifo_drop_i),
      .mb_hit_i  (fifo_mb_hit_i),
      .evt_o     (evt)
   );

   for (genvar i = 0; i < NUM_MB; i++) begin : g_set
      if (i >= REMAP_W) begin : g_plain
         assign set_vec[i] = done_i[i];
      end else if (i == OVF_BIT) begin : g_ovf
         assign set_vec[i] = mode_q ? evt.ovf : done_i[i];
      end else if (i == WARN_BIT) begin : g_warn
         assign set_vec[i] = mode_q ? evt.warn : done_i[i];
      end else if (i == AVAIL_BIT) begin : g_avail
         // a level source: the clear takes one cycle before it sets again
         assign set_vec[i] = mode_q ? (evt.avail && !clr_vec[i]) : done_i[i];
      end else begin : g_rsvd
         assign set_vec[i] = mode_q ? 1'b0 : done_i[i];
      end
   end

   msg_irq_flag_bank #(
      .W (NUM_MB)
   ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .zero_i  (zero_vec),
      .flags_o (flags_o)
   );

   msg_irq_req #(
      .W (NUM_MB)
   ) u_req (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .flags_i      (flags_o),
      .irq_o        (irq_o)
   );

   assign fifo_mode_o = mode_q;

   // R8
   rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_mode_o |-> (flags_o[AVAIL_BIT-1:0] == '0));

   // R4
   ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flags_o[OVF_BIT]) && $past(fifo_mode_o))
         |-> $past(fifo_drop_i && !fifo_mb_hit_i));

   // R5
   warn_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flags_o[WARN_BIT]) && $past(fifo_mode_o))
         |-> ($past(fifo_cnt_i) == CNT_W'(WARN_LVL + 1)));

   // R9
   mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_wr_i && (mode_wdata_i == fifo_mode_o)) |=> $stable(fifo_mode_o));
endmodule

// File: tb/msg_irq_flags_bench.sv
`timescale 1ns/1ps
module msg_irq_flags_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] done = '0;
   logic        mode_wr = 1'b0;
   logic        mode_wd = 1'b0;
   logic [2:0]  cnt = '0;
   logic        drop = 1'b0;
   logic        hit = 1'b0;
   logic        clr_wr = 1'b0;
   logic [31:0] clr_wd = '0;
   logic        mask_wr = 1'b0;
   logic [31:0] mask_wd = '0;
   logic        fmode;
   logic [31:0] flags;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   msg_irq_flags u_msg_irq_flags (
      .clk_i (clk), .rst_ni (rst_n), .done_i (done),
      .mode_wr_i (mode_wr), .mode_wdata_i (mode_wd), .fifo_cnt_i (cnt),
      .fifo_drop_i (drop), .fifo_mb_hit_i (hit),
      .clr_wr_i (clr_wr), .clr_wdata_i (clr_wd),
      .mask_wr_i (mask_wr), .mask_wdata_i (mask_wd),
      .fifo_mode_o (fmode), .flags_o (flags), .irq_o (irq)
   );

   // {done, clear data, expected flags}; buffer mode, no mask
   localparam logic [95:0] VEC [6] = '{
      {32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
      {32'h8000_0100, 32'h0000_0000, 32'h8000_0101},
      {32'h0000_0000, 32'h0000_0001, 32'h8000_0100},
      {32'h0000_0100, 32'h0000_0100, 32'h8000_0100},
      {32'h00F0_0000, 32'h8000_0000, 32'h00F0_0100},
      {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one rising edge, then back to the falling edge; drop one-cycle strobes
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      done = '0; clr_wr = 1'b0; clr_wd = '0; mode_wr = 1'b0;
      mask_wr = 1'b0; drop = 1'b0; hit = 1'b0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11
      chk("R11 flags", flags, 32'h0);
      chk("R11 irq", {31'b0, irq}, 32'h0);
      chk("R11 mode", {31'b0, fmode}, 32'h0);

      // R1/R2/R3 vector walk
      for (int k = 0; k < 6; k++) begin
         done   = VEC[k][95:64];
         clr_wd = VEC[k][63:32];
         clr_wr = |VEC[k][63:32];
         step();
         chk("R1/R2/R3 vector", flags, VEC[k][31:0]);
      end

      // R10 latency
      mask_wr = 1'b1; mask_wd = 32'hFFFF_FFFF; done = 32'h8;
      step();
      chk("R10 irq not early", {31'b0, irq}, 32'h0);
      step();
      chk("R10 irq after one cycle", {31'b0, irq}, 32'h1);
      clr_wr = 1'b1; clr_wd = 32'h8;
      step();
      chk("R3 clear", flags, 32'h0);
      chk("R10 irq lags clear", {31'b0, irq}, 32'h1);
      step();
      chk("R10 irq drops", {31'b0, irq}, 32'h0);
      mask_wr = 1'b1; mask_wd = 32'h1; done = 32'h200;
      step();
      step();
      chk("R10 masked flag", {31'b0, irq}, 32'h0);

      // R9 mode writes
      done = 32'h4;
      step();
      mode_wr = 1'b1; mode_wd = 1'b0;
      step();
      chk("R9 same-value write", flags, 32'h204);
      mode_wr = 1'b1; mode_wd = 1'b1;
      step();
      chk("R9 mode change clears low byte", flags, 32'h200);
      chk("R9 mode on", {31'b0, fmode}, 32'h1);

      // R8 reserved / ignored pulses
      done = 32'hFF;
      step();
      chk("R8 low pulses ignored", flags, 32'h200);

      // R7 availability
      cnt = 3'd1;
      step();
      chk("R7 avail set", flags, 32'h220);
      clr_wr = 1'b1; clr_wd = 32'h20;
      step();
      chk("R7 clear takes effect", flags, 32'h200);
      step();
      chk("R7 re-asserts", flags, 32'h220);

      // R5 / R6 warning
      cnt = 3'd2; step();
      cnt = 3'd3; step();
      cnt = 3'd4; step();
      chk("R5 no warn at 4", flags, 32'h220);
      cnt = 3'd5; step();
      chk("R5 warn on 4 to 5", flags, 32'h260);
      clr_wr = 1'b1; clr_wd = 32'h40;
      step();
      chk("R6 cleared above 4", flags, 32'h220);
      cnt = 3'd6; step();
      cnt = 3'd5; step();
      chk("R6 no re-set above 4", flags, 32'h220);
      cnt = 3'd4; step();
      cnt = 3'd5; step();
      chk("R6 re-armed", flags, 32'h260);
      clr_wr = 1'b1; clr_wd = 32'h40;
      step();
      cnt = 3'd3; step();
      cnt = 3'd5; step();
      chk("R5 jump 3 to 5 ignored", flags, 32'h220);

      // R4 overflow
      drop = 1'b1; hit = 1'b1;
      step();
      chk("R4 mailbox took frame", flags, 32'h220);
      drop = 1'b1;
      step();
      chk("R4 overflow", flags, 32'h2A0);

      // R9 back to buffer mode, R2 count no effect
      mode_wr = 1'b1; mode_wd = 1'b0;
      step();
      chk("R9 mode off clears low byte", flags, 32'h200);
      step();
      chk("R2 count ignored in buffer mode", flags, 32'h200);

      finish_run();
   end
endmodule